// File: doc/BRIEF.md
# Paired-Bayer Defective Pixel Corrector

This block sits on a raw mosaic stream of 10-bit samples and repairs isolated stuck-high or stuck-low pixels. The colour filter repeats in pairs of rows: every row of an even row pair carries red and green, every row of an odd row pair carries green and blue. The pixel colour therefore follows from the pair parity and the column parity alone, and both rows of a pair share one pattern. For each sample the block gathers three neighbours of the same colour: two columns to the left, two columns to the right, and the same column in the other row of its own pair. A pixel that stands above all three by more than a programmable threshold, or below all three by more than it, is replaced by the median of the three. Every other pixel passes through unchanged.

The stream carries a valid strobe, a line-start flag and a frame-start flag. Each frame has exactly `LINE_W` samples per line and `FRAME_H` lines, with `FRAME_H` even. A two-pixel border on every side of the frame is never corrected. The output stream is the input stream delayed by a fixed `LINE_W + 2` accepted samples, and its sideband flags are delayed by the same amount. The stream may stall for any number of cycles between samples. The last samples of one frame leave the block as the first samples of the next frame enter it.

Top module: `bayer_defect_corrector`

## Requirements
- R1: After reset, out_valid, out_sol and out_sof are low. They stay low until more than LINE_W+2 samples have been accepted.
- R2: A sample is accepted on each clock edge where in_valid is high. Once the pipeline is full, each accepted sample produces one output in the next cycle. That output is the sample accepted LINE_W+2 samples earlier, and it is passed through unchanged unless it is a defect. out_valid is low in any cycle that follows an edge where in_valid was low.
- R3: out_sol and out_sof equal the in_sol and in_sof values of the same delayed sample. out_sof is never high without out_sol and out_valid.
- R4: A pixel's colour is red for an even row pair with an even column, blue for an odd row pair with an odd column, and green otherwise. The pair index is row/2. The same-colour neighbours are columns c-2 and c+2 of row r, and column c of row r XOR 1.
- R5: An interior pixel that exceeds each of its three neighbours by more than the threshold is flagged as hot.
- R6: An interior pixel that is lower than each of its three neighbours by more than the threshold is flagged as cold.
- R7: A flagged pixel is output as the median of its three same-colour neighbours.
- R8: A difference exactly equal to the threshold does not flag a pixel.
- R9: Pixels in rows 0, 1, FRAME_H-2 and FRAME_H-1, and pixels in columns 0, 1, LINE_W-2 and LINE_W-1, are output unchanged.
- R10: With thresh at its maximum code (1023), every pixel is output unchanged.
- R11: A pixel that exceeds only some of its neighbours by more than the threshold, or falls below only some of them by more than it, is output unchanged.
- R12: The threshold used for a pixel is the value on thresh in the cycle its output is produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample strobe |
| in_sol | input | 1 | First sample of a line |
| in_sof | input | 1 | First sample of a frame (set together with in_sol) |
| in_pix | input | 10 | Raw mosaic sample |
| thresh | input | 10 | Defect threshold; 1023 disables correction |
| out_valid | output | 1 | Output sample strobe |
| out_sol | output | 1 | Delayed line-start flag |
| out_sof | output | 1 | Delayed frame-start flag |
| out_pix | output | 10 | Corrected sample |

## Verification
The assertions take the input framing as given. Every line holds exactly LINE_W samples, every frame holds FRAME_H lines, and frame start comes only together with line start. Without this framing the recovered row and column of the centre pixel would be meaningless. The bench only ever sends whole frames with correct flags. It inserts random idle gaps between samples and changes the threshold between frames, so the threshold used for each output is the one sampled in the cycle that output appears. Stimulus mixes random spiky frames with directed frames: planted hot, cold, equal-threshold and partial outliers, border outliers, and a per-colour gradient in which choosing the wrong vertical partner row changes the median.

// File: rtl/bdc_pkg.sv
package bdc_pkg;
    localparam int PIX_W = 10;

    typedef logic [PIX_W-1:0] pix_t;

    typedef struct packed {
        logic vld;
        logic sof;
        logic sol;
    } side_t;

    // a exceeds b by strictly more than t, without wrap
    function automatic logic beyond(input pix_t a, input pix_t b, input pix_t t);
        logic [PIX_W:0] lim;
        lim = {1'b0, b} + {1'b0, t};
        return {1'b0, a} > lim;
    endfunction

    function automatic pix_t median3(input pix_t a, input pix_t b, input pix_t c);
        pix_t lo;
        pix_t hi;
        pix_t mid;
        lo  = (a < b) ? a : b;
        hi  = (a < b) ? b : a;
        mid = (hi < c) ? hi : c;
        return (lo > mid) ? lo : mid;
    endfunction
endpackage

// File: rtl/bdc_window.sv
module bdc_window
    import bdc_pkg::*;
#(
    parameter int LINE_W = 16
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  shift,
    input  pix_t  din,
    input  side_t sin,
    output pix_t  c_pix,
    output pix_t  l_pix,
    output pix_t  r_pix,
    output pix_t  up_pix,
    output pix_t  dn_pix,
    output side_t c_side
);
    localparam int DEPTH  = 2 * LINE_W + 2;
    localparam int TAP_C  = LINE_W + 1;
    localparam int TAP_L  = LINE_W + 3;
    localparam int TAP_R  = LINE_W - 1;
    localparam int TAP_UP = 2 * LINE_W + 1;
    localparam int TAP_DN = 1;
    localparam int SIDE_D = TAP_C + 1;

    pix_t  pix_sr  [DEPTH];
    side_t side_sr [SIDE_D];

    for (genvar i = 0; i < DEPTH; i++) begin : g_pix
        pix_t nxt;
        if (i == 0) begin : g_head
            assign nxt = din;
        end else begin : g_body
            assign nxt = pix_sr[i-1];
        end
        always_ff @(posedge clk) begin
            if (rst)        pix_sr[i] <= '0;
            else if (shift) pix_sr[i] <= nxt;
        end
    end

    for (genvar i = 0; i < SIDE_D; i++) begin : g_side
        side_t nxt;
        if (i == 0) begin : g_head
            assign nxt = sin;
        end else begin : g_body
            assign nxt = side_sr[i-1];
        end
        always_ff @(posedge clk) begin
            if (rst)        side_sr[i] <= '0;
            else if (shift) side_sr[i] <= nxt;
        end
    end

    assign c_pix  = pix_sr[TAP_C];
    assign l_pix  = pix_sr[TAP_L];
    assign r_pix  = pix_sr[TAP_R];
    assign up_pix = pix_sr[TAP_UP];
    assign dn_pix = pix_sr[TAP_DN];
    assign c_side = side_sr[TAP_C];
endmodule

// File: rtl/bdc_position.sv
module bdc_position #(
    parameter int LINE_W  = 16,
    parameter int FRAME_H = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic step,
    input  logic c_sof,
    input  logic c_sol,
    output logic row_odd,
    output logic interior
);
    localparam int RW = (FRAME_H > 2) ? $clog2(FRAME_H) : 2;
    localparam int CW = (LINE_W > 2) ? $clog2(LINE_W) : 2;
    localparam int MARGIN = 2;

    logic [RW-1:0] row_q, row_n;
    logic [CW-1:0] col_q, col_n;

    always_comb begin
        if (c_sof) begin
            row_n = '0;
            col_n = '0;
        end else if (c_sol) begin
            row_n = row_q + RW'(1);
            col_n = '0;
        end else begin
            row_n = row_q;
            col_n = col_q + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            row_q <= '0;
            col_q <= '0;
        end else if (step) begin
            row_q <= row_n;
            col_q <= col_n;
        end
    end

    assign row_odd  = row_n[0];
    assign interior = (row_n >= RW'(MARGIN)) && (row_n <= RW'(FRAME_H - 1 - MARGIN)) &&
                      (col_n >= CW'(MARGIN)) && (col_n <= CW'(LINE_W - 1 - MARGIN));
endmodule

// File: rtl/bdc_judge.sv
module bdc_judge
    import bdc_pkg::*;
(
    input  pix_t c_pix,
    input  pix_t l_pix,
    input  pix_t r_pix,
    input  pix_t up_pix,
    input  pix_t dn_pix,
    input  pix_t thresh,
    input  logic row_odd,
    input  logic interior,
    output pix_t partner_pix,
    output logic hot,
    output logic cold,
    output pix_t fixed_pix
);
    // lower row of a pair looks up, upper row looks down
    assign partner_pix = row_odd ? up_pix : dn_pix;

    assign hot  = interior && beyond(c_pix, l_pix, thresh) &&
                  beyond(c_pix, r_pix, thresh) && beyond(c_pix, partner_pix, thresh);
    assign cold = interior && beyond(l_pix, c_pix, thresh) &&
                  beyond(r_pix, c_pix, thresh) && beyond(partner_pix, c_pix, thresh);

    assign fixed_pix = (hot || cold) ? median3(l_pix, r_pix, partner_pix) : c_pix;
endmodule

// File: rtl/bayer_defect_corrector.sv
module bayer_defect_corrector
    import bdc_pkg::*;
#(
    parameter int LINE_W  = 16,
    parameter int FRAME_H = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             in_sol,
    input  logic             in_sof,
    input  logic [PIX_W-1:0] in_pix,
    input  logic [PIX_W-1:0] thresh,
    output logic             out_valid,
    output logic             out_sol,
    output logic             out_sof,
    output logic [PIX_W-1:0] out_pix
);
    pix_t  c_pix, l_pix, r_pix, up_pix, dn_pix, partner_pix, fixed_pix;
    side_t c_side, in_side;
    logic  row_odd, interior, hot, cold, emit;

    assign in_side = '{vld: 1'b1, sof: in_sof, sol: in_sol};
    assign emit    = in_valid && c_side.vld;

    bdc_window #(.LINE_W(LINE_W)) win_i (
        .clk(clk), .rst(rst), .shift(in_valid), .din(in_pix), .sin(in_side),
        .c_pix(c_pix), .l_pix(l_pix), .r_pix(r_pix), .up_pix(up_pix),
        .dn_pix(dn_pix), .c_side(c_side)
    );

    bdc_position #(.LINE_W(LINE_W), .FRAME_H(FRAME_H)) pos_i (
        .clk(clk), .rst(rst), .step(emit), .c_sof(c_side.sof), .c_sol(c_side.sol),
        .row_odd(row_odd), .interior(interior)
    );

    bdc_judge judge_i (
        .c_pix(c_pix), .l_pix(l_pix), .r_pix(r_pix), .up_pix(up_pix), .dn_pix(dn_pix),
        .thresh(thresh), .row_odd(row_odd), .interior(interior),
        .partner_pix(partner_pix), .hot(hot), .cold(cold), .fixed_pix(fixed_pix)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_sol   <= 1'b0;
            out_sof   <= 1'b0;
            out_pix   <= '0;
        end else begin
            out_valid <= emit;
            out_sol   <= emit && c_side.sol;
            out_sof   <= emit && c_side.sof;
            if (emit) out_pix <= fixed_pix;
        end
    end
endmodule

// File: rtl/bdc_checker.sv
module bdc_checker
    import bdc_pkg::*;
(
    input logic clk,
    input logic rst,
    input logic in_valid,
    input pix_t thresh,
    input logic out_valid,
    input logic out_sol,
    input logic out_sof,
    input pix_t out_pix,
    input pix_t c_pix,
    input pix_t l_pix,
    input pix_t r_pix,
    input pix_t partner_pix,
    input logic interior
);
    a_r2_output_needs_input: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid));

    a_r3_frame_flag_in_line_start: assert property (@(posedge clk) disable iff (rst)
        out_sof |-> (out_sol && out_valid));

    a_r3_line_flag_needs_valid: assert property (@(posedge clk) disable iff (rst)
        out_sol |-> out_valid);

    a_r10_max_threshold_passes: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(thresh) == '1) |-> out_pix == $past(c_pix));

    a_r9_border_untouched: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !$past(interior)) |-> out_pix == $past(c_pix));

    a_r7_replacement_is_neighbour: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_pix != $past(c_pix)) |->
            (out_pix == $past(l_pix) || out_pix == $past(r_pix) ||
             out_pix == $past(partner_pix)));
endmodule

bind bayer_defect_corrector bdc_checker chk_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .thresh(thresh),
    .out_valid(out_valid), .out_sol(out_sol), .out_sof(out_sof), .out_pix(out_pix),
    .c_pix(c_pix), .l_pix(l_pix), .r_pix(r_pix), .partner_pix(partner_pix),
    .interior(interior)
);

// File: tb/bayer_defect_corrector_tb.sv
module bayer_defect_corrector_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int W = 16;
    localparam int H = 8;
    localparam int D = W + 2;
    localparam int NF = 8;
    localparam int NS = 4096;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0, in_sol = 1'b0, in_sof = 1'b0;
    logic [9:0] in_pix = '0, thresh = '0;
    logic       out_valid, out_sol, out_sof;
    logic [9:0] out_pix;

    always #(CLK_PERIOD/2) clk = ~clk;

    bayer_defect_corrector #(.LINE_W(W), .FRAME_H(H)) dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sol(in_sol), .in_sof(in_sof),
        .in_pix(in_pix), .thresh(thresh), .out_valid(out_valid), .out_sol(out_sol),
        .out_sof(out_sof), .out_pix(out_pix)
    );

    int fr   [NF][H][W];
    int tagm [NF][H][W];
    int ftag [NF];
    int s_f [NS], s_r [NS], s_c [NS];
    int n_push = 0, n_acc = 0;
    int checks = 0, fails = 0;
    bit sv_v = 0, mon_en = 0, done = 0;
    int sv_t = 0;

    function automatic string tagname(int k);
        case (k)
            4:  return "R4 colour-neighbours";
            5:  return "R5 R7 hot";
            6:  return "R6 R7 cold";
            8:  return "R8 equal-threshold";
            9:  return "R9 border";
            10: return "R10 max-threshold";
            11: return "R11 partial-outlier";
            12: return "R12 threshold-switch";
            default: return "R2 pass";
        endcase
    endfunction

    function automatic int model(int f, int r, int c, int t, output int cat);
        int p, a, b, v, hi, lo, mx, mn;
        p = fr[f][r][c];
        if (r < 2 || r > H - 3 || c < 2 || c > W - 3) begin
            cat = 9;
            return p;
        end
        a = fr[f][r][c-2];
        b = fr[f][r][c+2];
        v = (r % 2 == 0) ? fr[f][r+1][c] : fr[f][r-1][c];
        hi = (p > a + t) && (p > b + t) && (p > v + t);
        lo = (p + t < a) && (p + t < b) && (p + t < v);
        cat = (tagm[f][r][c] != 0) ? tagm[f][r][c] : ftag[f];
        if (hi) cat = 5;
        if (lo) cat = 6;
        if (t >= 1023) cat = 10;
        if (!(hi || lo)) return p;
        mx = (a > b) ? a : b; mx = (mx > v) ? mx : v;
        mn = (a < b) ? a : b; mn = (mn < v) ? mn : v;
        return a + b + v - mx - mn;
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        sv_v <= in_valid && !rst;
        sv_t <= int'(thresh);
        if (in_valid && !rst) n_acc <= n_acc + 1;
    end

    always @(negedge clk) begin
        if (mon_en) begin
            if (sv_v && n_acc > D) begin
                int idx, cat, e;
                idx = n_acc - 1 - D;
                e = model(s_f[idx], s_r[idx], s_c[idx], sv_t, cat);
                chk(out_valid == 1'b1, "R2 valid", int'(out_valid), 1);
                chk(int'(out_pix) == e, tagname(cat), int'(out_pix), e);
                chk(out_sol == (s_c[idx] == 0) && out_sof == (s_c[idx] == 0 && s_r[idx] == 0),
                    "R3 sideband", int'({out_sof, out_sol}),
                    int'({s_c[idx] == 0 && s_r[idx] == 0, s_c[idx] == 0}));
            end else begin
                chk(out_valid == 1'b0, (n_acc <= D) ? "R1 fill" : "R2 idle",
                    int'(out_valid), 0);
            end
        end
    end

    task automatic send_frame(int f, int t, int gaps);
        for (int r = 0; r < H; r++) begin
            for (int c = 0; c < W; c++) begin
                if (gaps != 0) begin
                    int g;
                    g = $urandom_range(0, 3) == 0 ? $urandom_range(1, 3) : 0;
                    for (int k = 0; k < g; k++) begin
                        @(negedge clk);
                        in_valid = 1'b0;
                    end
                end
                @(negedge clk);
                if (r == 0 && c == 0) thresh = 10'(t);
                in_valid = 1'b1;
                in_pix = 10'(fr[f][r][c]);
                in_sol = (c == 0);
                in_sof = (c == 0 && r == 0);
                s_f[n_push] = f; s_r[n_push] = r; s_c[n_push] = c;
                n_push++;
            end
        end
    endtask

    task automatic fill_random(int f);
        int base;
        base = $urandom_range(100, 800);
        for (int r = 0; r < H; r++)
            for (int c = 0; c < W; c++) begin
                fr[f][r][c] = ($urandom_range(0, 7) == 0) ? $urandom_range(0, 1023)
                                                           : base + $urandom_range(0, 15);
                tagm[f][r][c] = 0;
            end
        ftag[f] = 2;
    endtask

    task automatic fill_directed(int f);
        for (int r = 0; r < H; r++)
            for (int c = 0; c < W; c++) begin
                fr[f][r][c] = 500;
                tagm[f][r][c] = 0;
            end
        ftag[f] = 2;
        fr[f][2][5] = 900;                        // R5 hot, upper row of pair
        fr[f][3][9] = 100;                        // R6 cold, lower row of pair
        fr[f][2][12] = 600; tagm[f][2][12] = 8;   // R8 exactly +threshold
        fr[f][5][6]  = 400; tagm[f][5][6]  = 8;   // R8 exactly -threshold
        fr[f][5][10] = 900; tagm[f][5][10] = 11;  // R11 partial outliers
        fr[f][5][12] = 900; tagm[f][5][12] = 11;
        fr[f][0][4] = 1000; fr[f][1][7] = 1000;   // R9 border outliers
        fr[f][6][5] = 1000; fr[f][7][9] = 1000;
        fr[f][3][0] = 1000; fr[f][4][1] = 1000;
        fr[f][3][14] = 1000; fr[f][4][15] = 0;
    endtask

    task automatic fill_gradient(int f);
        for (int r = 0; r < H; r++)
            for (int c = 0; c < W; c++) begin
                int pe, ce, base;
                pe = ((r / 2) % 2 == 0);
                ce = (c % 2 == 0);
                base = (pe && ce) ? 100 : (!pe && !ce) ? 400 : 250;
                fr[f][r][c] = base + 8 * c + 20 * r;
                tagm[f][r][c] = 0;
            end
        ftag[f] = 4;
        fr[f][2][6] = 1000;   // R4 green defect, partner row 3
        fr[f][5][9] = 0;      // R4 green defect, partner row 4
        fr[f][4][4] = 1000;   // R4 red defect, partner row 5
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(out_valid == 0 && out_sol == 0 && out_sof == 0, "R1 reset",
            int'({out_valid, out_sol, out_sof}), 0);
        mon_en = 1;

        fill_random(0);    send_frame(0, 60, 1);
        fill_directed(1);  send_frame(1, 100, 0);
        fill_directed(2);  send_frame(2, 1023, 1);
        fill_gradient(3);  send_frame(3, 30, 0);
        fill_random(4);    send_frame(4, 0, 1);
        fill_directed(5);  ftag[5] = 12; send_frame(5, 100, 1);
        fill_random(6);    send_frame(6, 120, 0);
        for (int r = 0; r < H; r++)
            for (int c = 0; c < W; c++) begin
                fr[7][r][c] = 512;
                tagm[7][r][c] = 0;
            end
        ftag[7] = 2;
        send_frame(7, 200, 0);
        @(negedge clk);
        in_valid = 1'b0;
        repeat (4) @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule